// File: doc/BRIEF.md
# Multi-CPU Level Interrupt Router

This block collects level-sensitive interrupt lines and steers each one to one or more of up to four processors. A single register port serves every CPU. A `perCpuSel` flag selects either the shared region or the banked region of the calling CPU, and `cpuId` names that CPU. Software enables or disables a shared source, and masks or unmasks it for its own CPU, by writing the source number to a dedicated set or clear register. It never rewrites a bitmap.

Each shared source has a routing word with two bits per CPU. A source reaches a CPU when at least one of its two bits is set. Two source numbers, 3 and 5, are private to each CPU. Each CPU drives them through its own line. They ignore the shared enable and the routing word and answer only to that CPU's mask. Every CPU has a level interrupt output and an acknowledge register that returns the lowest qualifying source number. Sources 0 and 1 normally carry the summaries of the inter-processor and message-signalled doorbells, but the router treats them like any other shared line.

Top module: `irq_router`

## Requirements
- R1: After reset every shared source is disabled and every source is masked on every CPU, so `irqOut` is all zero and each acknowledge read returns 1023 whatever the input levels are.
- R2: Writing a source number in wrData[9:0] to shared offset 0x030 enables that source. Writing it to shared offset 0x034 disables it.
- R3: Writing a source number to banked offset 0x048 masks that source for the CPU given by `cpuId` only. Writing it to banked offset 0x04C unmasks it for that CPU only.
- R4: The routing word of source n sits at shared offset 0x100 + 4n. Bit c (CPU c, normal) or bit 8+c (CPU c, alternate) routes the source to CPU c, and either bit is enough. A read returns bits [3:0] and [11:8] as written and zero elsewhere.
- R5: A read of shared offset 0x000 returns the number of sources in bits [11:2] and zero in all other bits.
- R6: A read of banked offset 0x044 returns in bits [9:0] the lowest-numbered source that qualifies for the calling CPU, or 1023 if none qualifies. Bits [31:10] are zero.
- R7: `irqOut[c]` is high exactly while some source qualifies for CPU c. An acknowledge read does not clear anything.
- R8: Sources 3 and 5 for CPU c come from `privLevel[2c]` and `privLevel[2c+1]`. They are gated only by CPU c's mask. `srcLevel[3]`, `srcLevel[5]`, the shared enable and the routing word have no effect on them.
- R9: A source number of NUM_SRC or more written to any set or clear register changes nothing.
- R10: Read data appears on `rdData` in the cycle after `rdEn`. A read of an unmapped offset, or of a routing word above the last source, returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuId | input | 2 | CPU issuing the access |
| perCpuSel | input | 1 | 1 = banked per-CPU region, 0 = shared region |
| addr | input | 12 | Byte offset within the region |
| wrEn | input | 1 | Write strobe |
| wrData | input | 32 | Write data |
| rdEn | input | 1 | Read strobe |
| rdData | output | 32 | Registered read data |
| srcLevel | input | NUM_SRC | Shared source levels |
| privLevel | input | 2*NUM_CPU | Private source levels, two per CPU |
| irqOut | output | NUM_CPU | Interrupt request per CPU |

## Verification
The bench builds the router with eight sources and four CPUs. Every source number, both private slots and every CPU then fit in an eight-bit input word. This lets the bench sweep all 256 shared-level patterns against a fixed mix of enables, masks and routing, and all 256 private-level patterns against mixed masks. It checks the acknowledge value and the interrupt line of each CPU against an arithmetic model. Each shared source is also walked alone through every CPU, alternating between the normal and alternate routing bit.

// File: rtl/irqr_pkg.sv
package irqr_pkg;
  localparam int ADDR_W   = 12;
  localparam int NUM_W    = 10;
  localparam int CPU_W    = 2;
  localparam int PRIV_A   = 3;
  localparam int PRIV_B   = 5;
  localparam logic [NUM_W-1:0] IDLE_NUM = 10'd1023;

  localparam logic [ADDR_W-1:0] OFS_CTRL   = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_EN_SET = 12'h030;
  localparam logic [ADDR_W-1:0] OFS_EN_CLR = 12'h034;
  localparam logic [ADDR_W-1:0] OFS_ACK    = 12'h044;
  localparam logic [ADDR_W-1:0] OFS_MK_SET = 12'h048;
  localparam logic [ADDR_W-1:0] OFS_MK_CLR = 12'h04C;
  localparam logic [ADDR_W-1:0] OFS_ROUTE  = 12'h100;

  typedef struct packed {
    logic             setEn;
    logic             clrEn;
    logic             setMask;
    logic             clrMask;
    logic             routeWr;
    logic             rdAny;
    logic             rdCtrl;
    logic             rdAck;
    logic             rdRoute;
    logic [NUM_W-1:0] num;
    logic [CPU_W-1:0] cpu;
    logic [7:0]       routeData;
  } strobe_t;
endpackage

// File: rtl/irqr_ctrl.sv
module irqr_ctrl
  import irqr_pkg::*;
(
  input  logic [CPU_W-1:0]  cpuId,
  input  logic              perCpuSel,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [31:0]       wrData,
  input  logic              rdEn,
  output strobe_t           strb
);
  logic             isRoute;
  logic [NUM_W-1:0] routeIdx;
  logic             unusedWrBits;

  assign isRoute      = !perCpuSel && (addr >= OFS_ROUTE) && (addr[1:0] == 2'b00);
  assign routeIdx     = addr[ADDR_W-1:2] - NUM_W'(OFS_ROUTE >> 2);
  assign unusedWrBits = ^wrData[31:12];

  always_comb begin
    strb           = '0;
    strb.cpu       = cpuId;
    strb.routeData = {wrData[11:8], wrData[3:0]};
    strb.num       = isRoute ? routeIdx : wrData[NUM_W-1:0];
    if (wrEn) begin
      strb.setEn   = !perCpuSel && addr == OFS_EN_SET;
      strb.clrEn   = !perCpuSel && addr == OFS_EN_CLR;
      strb.setMask =  perCpuSel && addr == OFS_MK_SET;
      strb.clrMask =  perCpuSel && addr == OFS_MK_CLR;
      strb.routeWr =  isRoute;
    end
    if (rdEn) begin
      strb.rdAny   = 1'b1;
      strb.rdCtrl  = !perCpuSel && addr == OFS_CTRL;
      strb.rdAck   =  perCpuSel && addr == OFS_ACK;
      strb.rdRoute =  isRoute;
    end
  end
endmodule

// File: rtl/irqr_datapath.sv
module irqr_datapath
  import irqr_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int NUM_SRC = 32
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  strobe_t                strb,
  input  logic [NUM_SRC-1:0]     srcLevel,
  input  logic [2*NUM_CPU-1:0]   privLevel,
  output logic [31:0]            rdData,
  output logic [NUM_CPU-1:0]     irqOut
);
  logic [NUM_SRC-1:0] enable;
  logic [NUM_SRC-1:0] maskQ  [NUM_CPU];
  logic [7:0]         route  [NUM_SRC];
  logic [NUM_SRC-1:0] qual   [NUM_CPU];
  logic [NUM_W-1:0]   ackNum [NUM_CPU];
  logic [31:0]        rdMux;
  logic               unusedSrc;

  assign unusedSrc = srcLevel[PRIV_A] ^ srcLevel[PRIV_B];

  // state updates: set/clear by source number
  always_ff @(posedge clk) begin
    if (!rstN) begin
      enable <= '0;
      for (int c = 0; c < NUM_CPU; c++) maskQ[c] <= '1;
      for (int s = 0; s < NUM_SRC; s++) route[s] <= '0;
    end else begin
      for (int s = 0; s < NUM_SRC; s++) begin
        if (strb.num == NUM_W'(s)) begin
          if (strb.setEn)   enable[s] <= 1'b1;
          if (strb.clrEn)   enable[s] <= 1'b0;
          if (strb.routeWr) route[s]  <= strb.routeData;
          for (int c = 0; c < NUM_CPU; c++) begin
            if (strb.cpu == CPU_W'(c)) begin
              if (strb.setMask) maskQ[c][s] <= 1'b1;
              if (strb.clrMask) maskQ[c][s] <= 1'b0;
            end
          end
        end
      end
    end
  end

  // qualification per CPU and source
  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      if (s == PRIV_A || s == PRIV_B) begin : g_priv
        assign qual[c][s] = privLevel[2*c + ((s == PRIV_B) ? 1 : 0)] & ~maskQ[c][s];
      end else begin : g_shared
        assign qual[c][s] = srcLevel[s] & enable[s] & ~maskQ[c][s]
                          & (route[s][c] | route[s][4+c]);
      end
    end

    always_comb begin
      ackNum[c] = IDLE_NUM;
      for (int s = NUM_SRC - 1; s >= 0; s--)
        if (qual[c][s]) ackNum[c] = NUM_W'(s);
    end

    assign irqOut[c] = |qual[c];

    assert_idle_code_R6: assert property (@(posedge clk) disable iff (!rstN)
      !irqOut[c] |-> ackNum[c] == IDLE_NUM) else $error("idle ack code");
    assert_ack_range_R6: assert property (@(posedge clk) disable iff (!rstN)
      irqOut[c] |-> ackNum[c] < NUM_W'(NUM_SRC)) else $error("ack out of range");
    assert_mask_set_R3: assert property (@(posedge clk) disable iff (!rstN)
      (strb.setMask && strb.cpu == CPU_W'(c) && strb.num == '0) |=> !qual[c][0])
      else $error("mask did not take");
  end

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_chk
    assert_set_enable_R2: assert property (@(posedge clk) disable iff (!rstN)
      (strb.setEn && strb.num == NUM_W'(s)) |=> enable[s]) else $error("enable set");
    assert_clr_enable_R2: assert property (@(posedge clk) disable iff (!rstN)
      (strb.clrEn && strb.num == NUM_W'(s)) |=> !enable[s]) else $error("enable clear");
  end

  // registered read path
  always_comb begin
    rdMux = '0;
    if (strb.rdCtrl) rdMux = 32'(NUM_SRC) << 2;
    if (strb.rdAck)
      for (int c = 0; c < NUM_CPU; c++)
        if (strb.cpu == CPU_W'(c)) rdMux = 32'(ackNum[c]);
    if (strb.rdRoute)
      for (int s = 0; s < NUM_SRC; s++)
        if (strb.num == NUM_W'(s)) rdMux = {20'd0, route[s][7:4], 4'd0, route[s][3:0]};
  end

  always_ff @(posedge clk) begin
    if (!rstN)          rdData <= '0;
    else if (strb.rdAny) rdData <= rdMux;
  end
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irqr_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int NUM_SRC = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [1:0]           cpuId,
  input  logic                 perCpuSel,
  input  logic [11:0]          addr,
  input  logic                 wrEn,
  input  logic [31:0]          wrData,
  input  logic                 rdEn,
  output logic [31:0]          rdData,
  input  logic [NUM_SRC-1:0]   srcLevel,
  input  logic [2*NUM_CPU-1:0] privLevel,
  output logic [NUM_CPU-1:0]   irqOut
);
  strobe_t strb;

  irqr_ctrl u_ctrl (
    .cpuId(cpuId), .perCpuSel(perCpuSel), .addr(addr),
    .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn), .strb(strb)
  );

  irqr_datapath #(.NUM_CPU(NUM_CPU), .NUM_SRC(NUM_SRC)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .srcLevel(srcLevel),
    .privLevel(privLevel), .rdData(rdData), .irqOut(irqOut)
  );
endmodule

// File: tb/irq_router_tb.sv
module irq_router_tb;
  localparam int NC = 4;
  localparam int NS = 8;

  logic        clk = 0;
  logic        rstN = 0;
  logic [1:0]  cpuId = 0;
  logic        perCpuSel = 0;
  logic [11:0] addr = 0;
  logic        wrEn = 0;
  logic [31:0] wrData = 0;
  logic        rdEn = 0;
  logic [31:0] rdData;
  logic [NS-1:0]   srcLevel = 0;
  logic [2*NC-1:0] privLevel = 0;
  logic [NC-1:0]   irqOut;

  int nChk = 0, nFail = 0;
  bit en [NS];
  bit msk [NC][NS];
  bit [7:0] rt [NS];

  always #5 clk = ~clk;

  irq_router #(.NUM_CPU(NC), .NUM_SRC(NS)) u_dut (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic busWr(bit pc, int cpu, int a, int d);
    @(negedge clk);
    perCpuSel = pc; cpuId = cpu[1:0]; addr = a[11:0]; wrData = d; wrEn = 1;
    @(negedge clk);
    wrEn = 0;
  endtask

  task automatic busRd(bit pc, int cpu, int a, output logic [31:0] v);
    @(negedge clk);
    perCpuSel = pc; cpuId = cpu[1:0]; addr = a[11:0]; rdEn = 1;
    @(negedge clk);
    rdEn = 0;
    v = rdData;
  endtask

  task automatic enSet(int s);   busWr(0, 0, 'h30, s); if (s < NS) en[s] = 1; endtask
  task automatic enClr(int s);   busWr(0, 0, 'h34, s); if (s < NS) en[s] = 0; endtask
  task automatic mkSet(int c, int s); busWr(1, c, 'h48, s); if (s < NS) msk[c][s] = 1; endtask
  task automatic mkClr(int c, int s); busWr(1, c, 'h4C, s); if (s < NS) msk[c][s] = 0; endtask
  task automatic rtWr(int s, bit [7:0] v);
    busWr(0, 0, 'h100 + 4*s, {20'd0, v[7:4], 4'd0, v[3:0]});
    rt[s] = v;
  endtask

  function automatic int expAck(int c);
    for (int s = 0; s < NS; s++) begin
      bit q;
      if (s == 3 || s == 5) q = privLevel[2*c + (s == 5 ? 1 : 0)] && !msk[c][s];
      else q = srcLevel[s] && en[s] && (rt[s][c] || rt[s][4+c]) && !msk[c][s];
      if (q) return s;
    end
    return 1023;
  endfunction

  task automatic checkAll(string tag);
    logic [31:0] v;
    for (int c = 0; c < NC; c++) begin
      busRd(1, c, 'h44, v);
      chk({tag, " R6 ack"}, v, expAck(c));
      chk({tag, " R7 irq"}, irqOut[c], expAck(c) != 1023);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    logic [31:0] v;
    for (int s = 0; s < NS; s++) begin
      en[s] = 0; rt[s] = 0;
      for (int c = 0; c < NC; c++) msk[c][s] = 1;
    end
    repeat (3) @(negedge clk);
    rstN = 1;
    srcLevel = '1; privLevel = '1;
    @(negedge clk);
    // R1: reset state with all levels high
    chk("R1 irq after reset", irqOut, 0);
    checkAll("R1");

    // R5: source count
    busRd(0, 0, 'h000, v);
    chk("R5 ctrl", v, NS << 2);

    // R10: unmapped and out-of-range route reads
    busRd(0, 0, 'h040, v);
    chk("R10 unmapped", v, 0);
    busRd(0, 0, 'h100 + 4*NS, v);
    chk("R10 route beyond", v, 0);

    // R4: route readback keeps only routing bits
    busWr(0, 0, 'h104, 32'hFFFF_FFFF);
    busRd(0, 0, 'h104, v);
    chk("R4 readback", v, 32'h0000_0F0F);
    rtWr(1, 8'h00);

    // R9: out-of-range numbers ignored
    enSet(NS); mkClr(0, NS); mkClr(1, NS + 2);
    checkAll("R9");

    // R2 R3 R4: walk each shared source through each CPU
    for (int s = 0; s < NS; s++) begin
      if (s == 3 || s == 5) continue;
      for (int c = 0; c < NC; c++) begin
        bit [7:0] r = ((s + c) % 2) ? (8'h01 << c) : (8'h10 << c);
        rtWr(s, r);
        enSet(s);
        checkAll("R1 still masked");
        mkClr(c, s);
        checkAll("R4 routed");
        busRd(0, 0, 'h100 + 4*s, v);
        chk("R4 route read", v, {20'd0, r[7:4], 4'd0, r[3:0]});
        enClr(s);
        checkAll("R2 disabled");
        enSet(s);
        mkSet(c, s);
        checkAll("R3 masked");
        enClr(s);
        rtWr(s, 8'h00);
      end
    end

    // R8: private sources
    srcLevel = 8'h28;
    enSet(3); enSet(5); rtWr(3, 8'hFF); rtWr(5, 8'hFF);
    for (int c = 0; c < NC; c++) begin mkClr(c, 3); mkClr(c, 5); end
    mkSet(2, 5); mkSet(1, 3);
    for (int p = 0; p < 256; p++) begin
      privLevel = p[7:0];
      checkAll("R8 private");
    end
    enClr(3); enClr(5); rtWr(3, 0); rtWr(5, 0);
    privLevel = 8'h00;
    checkAll("R8 priv low");

    // R6 R7 R3: priority sweep with mixed routing and masks
    for (int s = 0; s < NS; s++) begin
      enSet(s);
      rtWr(s, (s % 2) ? 8'hF0 : 8'h0F);
      for (int c = 0; c < NC; c++) mkClr(c, s);
    end
    rtWr(4, 8'h05);
    mkSet(1, 2); mkSet(3, 6); mkSet(0, 0);
    for (int p = 0; p < 256; p++) begin
      srcLevel = p[7:0];
      privLevel = p[7:0] ^ 8'h5A;
      checkAll("R6 priority");
    end

    // R7: repeated acknowledges do not clear
    srcLevel = 8'h04; privLevel = 0;
    checkAll("R7 first");
    checkAll("R7 second");

    // R2: clear all enables
    srcLevel = '1;
    for (int s = 0; s < NS; s++) enClr(s);
    checkAll("R2 all off");

    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule